// File: doc/BRIEF.md
# Host-Side Serial Boot Streamer

This block lives on a host device and loads a boot table into a DSP over a synchronous serial link. The host generates the bit clock, the frame sync and the data line itself. After a start command the block waits for the target to pull its ready flag low. A low flag means the target's receive port is armed. The block then runs the bit clock for a short settling interval. After that it shifts out each word delivered by host logic on a valid/ready stream, one frame per word.

Each word is preceded by a one-bit-period frame sync pulse and is sent MSB first. Data changes only on falling clock edges, so it is steady when the target samples on rising edges. Between words the clock is parked low for a guaranteed idle gap, which gives the target time to move each word out of its receive register. The first word on the stream is the boot keyword, and the block keeps the stream order. When the word flagged as last has fully left the wire, a one-cycle done pulse ends the session.

The half-period of the bit clock and the idle gap are parameters counted in system clock cycles. A half-period of at least one cycle keeps the bit clock at or below half the system clock rate.

Top module: `sbs_streamer`

## Requirements
- R1: Out of reset and whenever the block is idle, `sclk`, `fsync`, `sdata`, `busy`, `in_ready` and `done` are all low.
- R2: A `start` pulse makes `busy` go high. No bit clock edge and no frame sync occurs while the ready input `rdy_n_in` is high (1 = not ready). `rdy_n_in` passes through a two-flop synchronizer before it is used.
- R3: While running, every high phase and every in-frame low phase of `sclk` lasts exactly `DIV_HALF` system cycles, with `DIV_HALF` >= 1.
- R4: After the synchronized ready flag is seen low, exactly `SETTLE_BITS` rising edges of `sclk` occur before the first frame sync.
- R5: Each word is one frame of `WORD_W`+1 bit periods. `fsync` is high during the first period only and is seen high on exactly one rising edge. The next `WORD_W` rising edges carry the word on `sdata`, MSB first. `sdata` and `fsync` never change while `sclk` is high.
- R6: Between the falling edge that ends one word and the rising of the next `fsync`, at least `GAP_CYC` system cycles pass with `sclk` held low.
- R7: A word is taken when `in_ready` and `in_valid` are both high on a clock edge. `in_ready` is high only while the line is idle between frames, and no frame starts while `in_valid` is low. Words go out in the order they are taken, so the first word taken (the boot keyword) is the first word sent.
- R8: `done` pulses for one cycle at the clock edge where the last word's final bit period ends (`sclk` falls). In that same cycle `busy` drops, having been high since `start`.
- R9: A `start` pulse while `busy` is high has no effect on the words sent or on the session.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a boot session (ignored while busy) |
| rdy_n_in | input | 1 | Target ready flag, asynchronous, low = ready |
| in_data | input | WORD_W | Boot word from host logic |
| in_valid | input | 1 | `in_data` holds a word |
| in_last | input | 1 | The offered word is the final one |
| in_ready | output | 1 | Block accepts a word on this edge |
| sclk | output | 1 | Serial bit clock to the target |
| fsync | output | 1 | Frame sync, one bit period ahead of the MSB |
| sdata | output | 1 | Serial data, MSB first |
| busy | output | 1 | Session in progress |
| done | output | 1 | One-cycle pulse after the last word |

## Verification
The bench acts as a receiving target. It shifts in `sdata` on each rising `sclk` after a sampled frame sync and compares every word with the expected list. The words used are a keyword, a walking one across all sixteen positions, and all-ones, all-zeros and a mixed word. Together these reveal bit order, stuck or shifted positions and dropped or repeated words. One session holds the ready flag high for a long time before releasing it, to show the clock stays quiet and the settle count starts at the right point. A second session begins with the flag already low and sends a single word, which checks the settle count and the done timing when the first word is also the last. A valid stall in mid-table, with a stray `start` pulse inside it, tells gap timing apart from waiting for data and shows the extra start does nothing.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_SETTLE,
    ST_FETCH,
    ST_FRAME,
    ST_GAP
  } sbs_state_e;

  // system cycles in one full bit period
  function automatic int sbs_bit_cycles(input int half);
    return 2 * half;
  endfunction

  // system cycles covered by one frame: sync period plus data periods
  function automatic int sbs_frame_cycles(input int half, input int width);
    return sbs_bit_cycles(half) * (width + 1);
  endfunction

endpackage

// File: rtl/sbs_sync.sv
module sbs_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sbs_bitclk.sv
module sbs_bitclk #(
  parameter int DIV_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic fall_tk
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

  logic [CW-1:0] cnt;
  logic          at_flip;

  assign at_flip = run && (cnt == CW'(DIV_HALF - 1));
  assign fall_tk = at_flip && sclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (!run) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (at_flip) begin
      cnt  <= '0;
      sclk <= ~sclk;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R3: a stopped clock always rests low
  p_park_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run) && !run |-> !sclk);
endmodule

// File: rtl/sbs_streamer.sv
module sbs_streamer
  import sbs_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int DIV_HALF    = 2,
  parameter int GAP_CYC     = 40,
  parameter int SETTLE_BITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              rdy_n_in,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              in_last,
  output logic              in_ready,
  output logic              sclk,
  output logic              fsync,
  output logic              sdata,
  output logic              busy,
  output logic              done
);
  localparam int BW = $clog2(WORD_W + 1);
  localparam int GW = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;
  localparam int SW = (SETTLE_BITS > 1) ? $clog2(SETTLE_BITS) : 1;

  sbs_state_e        st;
  logic              rdy_n_s;
  logic              run;
  logic              fall_tk;
  logic [WORD_W-1:0] sh;
  logic [BW-1:0]     bcnt;
  logic [GW-1:0]     gcnt;
  logic [SW-1:0]     scnt;
  logic              last_q;

  // named events
  logic frame_start;
  logic word_end;
  logic settle_end;

  sbs_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (rdy_n_in),
    .q    (rdy_n_s)
  );

  assign run = (st == ST_SETTLE) || (st == ST_FRAME);

  sbs_bitclk #(.DIV_HALF(DIV_HALF)) u_clk (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .sclk   (sclk),
    .fall_tk(fall_tk)
  );

  assign frame_start = (st == ST_FETCH) && in_valid;
  assign word_end    = (st == ST_FRAME) && fall_tk && (bcnt == BW'(WORD_W));
  assign settle_end  = (st == ST_SETTLE) && fall_tk && (scnt == SW'(SETTLE_BITS - 1));
  assign in_ready    = (st == ST_FETCH);
  assign busy        = (st != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      fsync  <= 1'b0;
      sdata  <= 1'b0;
      sh     <= '0;
      bcnt   <= '0;
      gcnt   <= '0;
      scnt   <= '0;
      last_q <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE:   if (start) st <= ST_WAIT;
        ST_WAIT: begin
          scnt <= '0;
          if (!rdy_n_s) st <= ST_SETTLE;
        end
        ST_SETTLE: begin
          if (settle_end)   st   <= ST_FETCH;
          else if (fall_tk) scnt <= scnt + 1'b1;
        end
        ST_FETCH: begin
          if (frame_start) begin
            sh     <= in_data;
            last_q <= in_last;
            fsync  <= 1'b1;
            sdata  <= 1'b0;
            bcnt   <= '0;
            st     <= ST_FRAME;
          end
        end
        ST_FRAME: begin
          if (word_end) begin
            fsync <= 1'b0;
            sdata <= 1'b0;
            gcnt  <= '0;
            if (last_q) begin
              st   <= ST_IDLE;
              done <= 1'b1;
            end else begin
              st <= ST_GAP;
            end
          end else if (fall_tk) begin
            fsync <= 1'b0;
            sdata <= sh[WORD_W-1];
            sh    <= {sh[WORD_W-2:0], 1'b0};
            bcnt  <= bcnt + 1'b1;
          end
        end
        ST_GAP: begin
          if (gcnt == GW'(GAP_CYC - 1)) st   <= ST_FETCH;
          else                          gcnt <= gcnt + 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // ---------------- checking ----------------
  int   gap_seen;
  int   frame_len;
  logic ended;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_seen  <= 0;
      frame_len <= 0;
      ended     <= 1'b0;
    end else begin
      if (!busy)         ended <= 1'b0;
      else if (word_end) ended <= 1'b1;
      if (word_end)              gap_seen <= 0;
      else if (gap_seen < GAP_CYC + 8) gap_seen <= gap_seen + 1;
      if (frame_start)   frame_len <= 0;
      else               frame_len <= frame_len + 1;
    end
  end

  p_idle_lines_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk && !fsync && !sdata && !in_ready);

  p_quiet_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT) |-> !sclk && !fsync);

  p_sync_one_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fsync) |-> $past(fall_tk));

  p_data_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sclk && $past(sclk) |-> $stable(sdata) && $stable(fsync));

  p_frame_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    word_end |-> frame_len == sbs_frame_cycles(DIV_HALF, WORD_W) - 1);

  p_gap_min_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fsync) && ended |-> gap_seen >= GAP_CYC);

  p_take_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !sclk && !fsync);

  p_done_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy) && !sclk);
endmodule

// File: tb/sbs_streamer_test.sv
`timescale 1ns/1ps
module sbs_streamer_test;
  localparam int WORD_W = 16;
  localparam int DIV_HALF = 2;
  localparam int GAP_CYC = 40;
  localparam int SETTLE_BITS = 2;
  localparam int NW = 21;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic rdy_n_in = 1'b1;
  logic [WORD_W-1:0] in_data = '0;
  logic in_valid = 1'b0;
  logic in_last = 1'b0;
  logic in_ready, sclk, fsync, sdata, busy, done;

  always #2.5 clk = ~clk;

  sbs_streamer #(.WORD_W(WORD_W), .DIV_HALF(DIV_HALF), .GAP_CYC(GAP_CYC),
                 .SETTLE_BITS(SETTLE_BITS)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .rdy_n_in(rdy_n_in),
    .in_data(in_data), .in_valid(in_valid), .in_last(in_last),
    .in_ready(in_ready), .sclk(sclk), .fsync(fsync), .sdata(sdata),
    .busy(busy), .done(done));

  int checks = 0;
  int errors = 0;
  logic [WORD_W-1:0] exp_w [NW];

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // receiver model of the target
  int cyc = 0;
  logic prev_sclk = 1'b0, prev_fsync = 1'b0, prev_busy = 1'b0, prev_done = 1'b0;
  logic prev_sdata = 1'b0;
  int run_len = 0;
  int rx_cnt = -1;
  logic [WORD_W-1:0] rx_sh = '0;
  int rx_idx = 0;
  int last_fall = 0;
  int rises = 0;
  bit settle_arm = 0;
  int done_cnt = 0;
  bit sync_prev_rise = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (sclk == prev_sclk) run_len++;
      else begin
        if (prev_sclk) check(run_len == DIV_HALF, "R3 high phase", run_len, DIV_HALF);
        else if (rx_cnt >= 1) check(run_len == DIV_HALF, "R3 low phase", run_len, DIV_HALF);
        run_len = 1;
      end
      if (prev_sclk && sclk && (sdata !== prev_sdata || fsync !== prev_fsync))
        check(0, "R5 change while high", 1, 0);
      if (fsync && !prev_fsync) begin
        if (settle_arm) begin
          check(rises == SETTLE_BITS, "R4 settle rises", rises, SETTLE_BITS);
          settle_arm = 0;
        end else begin
          check(cyc - last_fall >= GAP_CYC, "R6 gap", cyc - last_fall, GAP_CYC);
        end
      end
      if (sclk && !prev_sclk) begin
        rises++;
        if (fsync) begin
          if (rx_cnt >= 0 || sync_prev_rise) check(0, "R5 sync mid-frame", rx_cnt, -1);
          rx_cnt = 0;
          sync_prev_rise = 1;
        end else begin
          sync_prev_rise = 0;
          if (rx_cnt >= 0) begin
            rx_sh = {rx_sh[WORD_W-2:0], sdata};
            rx_cnt++;
            if (rx_cnt == WORD_W) begin
              if (rx_idx < NW)
                check(rx_sh == exp_w[rx_idx], "R5 word", int'(rx_sh), int'(exp_w[rx_idx]));
              else check(0, "R7 extra word", rx_idx, NW);
              rx_idx++;
              rx_cnt = -1;
            end
          end
        end
      end
      if (!sclk && prev_sclk) last_fall = cyc;
      if (done) begin
        done_cnt++;
        check(!busy && prev_busy && !sclk && prev_sclk && !prev_done && rx_cnt == -1,
              "R8 done timing", int'(busy), 0);
      end
      prev_sclk = sclk; prev_fsync = fsync; prev_busy = busy;
      prev_done = done; prev_sdata = sdata;
    end
  end

  task automatic send(input logic [WORD_W-1:0] w, input logic last);
    @(negedge clk);
    in_data = w; in_valid = 1'b1; in_last = last;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit quiet;
    exp_w[0] = 16'h10AA;
    for (int k = 0; k < 16; k++) exp_w[1 + k] = 16'(1) << (15 - k);
    exp_w[17] = 16'hFFFF;
    exp_w[18] = 16'h0000;
    exp_w[19] = 16'hA5C3;
    exp_w[20] = 16'h8001;

    repeat (4) @(negedge clk);
    // R1 reset state
    check(!sclk && !fsync && !sdata && !busy && !in_ready && !done, "R1 reset idle",
          int'({sclk, fsync, sdata, busy, in_ready, done}), 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check(!sclk && !fsync && !busy, "R1 idle without start", int'({sclk, fsync, busy}), 0);

    // session 1: ready held high for a while
    pulse_start();
    repeat (100) @(negedge clk);
    check(busy, "R2 busy after start", int'(busy), 1);
    check(rises == 0 && !fsync, "R2 no clock before ready", rises, 0);
    @(posedge clk); #1;
    rises = 0; settle_arm = 1; rdy_n_in = 1'b0;

    for (int i = 0; i < 20; i++) begin
      if (i == 10) begin
        quiet = 1;
        while (!in_ready) @(negedge clk);
        for (int s = 0; s < 30; s++) begin
          @(negedge clk);
          if (s == 5) start = 1'b1;
          if (s == 6) start = 1'b0;
          if (sclk || fsync || !in_ready || !busy) quiet = 0;
        end
        check(quiet, "R7 hold while no valid", int'(quiet), 1);
        check(rx_idx == 10, "R9 stray start no effect", rx_idx, 10);
      end
      send(exp_w[i], i == 19);
    end
    while (done_cnt < 1) @(negedge clk);
    repeat (5) @(negedge clk);
    check(rx_idx == 20, "R7 word count session 1", rx_idx, 20);
    check(!busy && !sclk && !fsync && !sdata && !in_ready, "R1 idle after done",
          int'({busy, sclk, fsync, sdata, in_ready}), 0);
    check(done_cnt == 1, "R8 one done pulse", done_cnt, 1);

    // session 2: ready already low, single last word
    @(posedge clk); #1;
    rises = 0; settle_arm = 1;
    pulse_start();
    send(exp_w[20], 1'b1);
    while (done_cnt < 2) @(negedge clk);
    repeat (5) @(negedge clk);
    check(rx_idx == 21, "R7 word count session 2", rx_idx, 21);
    check(!settle_arm, "R4 settle seen session 2", int'(settle_arm), 0);
    check(!busy && done_cnt == 2, "R8 session 2 end", done_cnt, 2);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule